// File: doc/BRIEF.md
# Threshold-Based Link Power Gating Controller

This block decides, for a single on-chip network link, when the link is switched off to save power and when it comes back. While the link is enabled, the controller watches a flit-valid strobe and counts the cycles in which a flit crosses the link during an observation window of programmable length. On the last cycle of each window it compares that count with a statically chosen threshold. If the link carried fewer flits than the threshold, the controller drops its link-enable output.

Once the link is off, it stays off for a programmable number of cycles. It then re-enables itself on a timer, without waiting for traffic to ask for it. No evaluation takes place while the link is down, and a fresh window with a cleared count begins on the cycle the link returns. A one-cycle status pulse marks every window that was evaluated. Draining in-flight flits and the power switch itself belong to the surrounding logic.

Top module: `lpg_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `link_en` is 1 and `win_done` is 0.
- R2: Utilization is the number of cycles in a window, while `link_en` is 1, in which `flit_vld` is 1. A window lasts `win_len` cycles, and a `win_len` of 0 is treated as 1. The count saturates at the window length.
- R3: On the last cycle of a window, if `thresh` is non-zero and the utilization (including that cycle) is strictly less than `thresh`, then `link_en` is 0 from the following cycle.
- R4: If the utilization is greater than or equal to `thresh`, `link_en` stays 1 and the next window starts on the next cycle with a count of zero.
- R5: A `thresh` of 0 never turns the link off.
- R6: Once `link_en` falls, it stays 0 for exactly `off_len` cycles and then returns to 1. An `off_len` of 0 is treated as 1. A new window starts on the cycle `link_en` returns to 1.
- R7: While `link_en` is 0, `flit_vld` is ignored and no window is evaluated.
- R8: `win_done` is 1 for one cycle, the cycle after each evaluated window end, whatever the decision was. It is never 1 in a cycle that follows a cycle with `link_en` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flit_vld | input | 1 | A flit crosses the link this cycle |
| thresh | input | CNT_W | Utilization threshold, 0 disables gating |
| win_len | input | CNT_W | Observation window length in cycles |
| off_len | input | OFF_W | Cycles the link stays off after a gating decision |
| link_en | output | 1 | 1 = link powered and usable |
| win_done | output | 1 | Pulse after each evaluated window |

## Verification
The bench builds the controller with its default widths of 16 bits for both the window and off-time fields, but it programs short windows (1 to 16 cycles) and short off times (0 to 7 cycles). This keeps every window boundary, every off interval and the return to a fresh window within a few dozen cycles. It uses those short windows to reach the edge cases: a window of one cycle, a utilization exactly equal to the threshold, and a threshold above the window length that exposes saturation. It also sends traffic during the off interval to show that the count is cleared across the outage.

// File: rtl/lpg_pkg.sv
// Shared types for the link power gating controller.
// Assumes nothing beyond standard SystemVerilog packages.
package lpg_pkg;

    // Controller phase: link up and observing, or link gated off.
    typedef enum logic {
        PH_OBSERVE = 1'b0,
        PH_GATED   = 1'b1
    } lpg_phase_e;

endpackage : lpg_pkg

// File: rtl/lpg_win_timer.sv
// Observation window timer.
// Counts cycles while 'run' is high and flags the last cycle of each window.
// Assumes: a win_len of 0 is handled as a one-cycle window; a window length
// lowered mid-window ends the current window at the next evaluation.
module lpg_win_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] win_len,
    output logic             last
);

    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] last_pos;

    // Index of the final cycle in a window, with zero length mapped to one.
    always_comb begin
        last_pos = (win_len == '0) ? '0 : win_len - 1'b1;
    end

    // Flag the final window cycle only while observing.
    always_comb begin
        last = run && (pos_q >= last_pos);
    end

    // Advance the position, wrap at the window end, clear when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pos_q <= '0;
        end else if (last) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_q + 1'b1;
        end
    end

endmodule : lpg_win_timer

// File: rtl/lpg_util_cnt.sv
// Link utilization counter.
// Counts cycles with a valid flit and saturates at the window length.
// 'total' gives the count including the current cycle, for the decision.
// Assumes: 'clr' is raised on the last window cycle and while gated.
module lpg_util_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] win_len,
    output logic [CNT_W-1:0] total
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cap;

    // Saturation ceiling, never below one.
    always_comb begin
        cap = (win_len == '0) ? CNT_W'(1) : win_len;
    end

    // Count including this cycle's flit, held at the ceiling.
    always_comb begin
        if (inc && (cnt_q < cap)) begin
            total = cnt_q + 1'b1;
        end else begin
            total = cnt_q;
        end
    end

    // Store the running count or clear it for a new window.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= total;
        end
    end

endmodule : lpg_util_cnt

// File: rtl/lpg_off_timer.sv
// Gated-interval timer.
// Loaded on the gating decision, expires after the programmed off time.
// Assumes: an off length of 0 is handled as one cycle.
module lpg_off_timer #(
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             active,
    input  logic [OFF_W-1:0] off_len,
    output logic             expire
);

    logic [OFF_W-1:0] left_q;

    // Expiry on the final gated cycle.
    always_comb begin
        expire = active && (left_q == '0);
    end

    // Load remaining cycles minus one, then count down while gated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= (off_len == '0) ? '0 : off_len - 1'b1;
        end else if (active && (left_q != '0)) begin
            left_q <= left_q - 1'b1;
        end
    end

endmodule : lpg_off_timer

// File: rtl/lpg_ctrl.sv
// Threshold-based link power gating controller (top).
// Observes link utilization per window, gates the link off when the count
// is below a non-zero threshold, and re-enables it after a fixed off time.
// Assumes: thresh, win_len and off_len are quasi-static; rst_n synchronous.
module lpg_ctrl #(
    parameter int CNT_W = 16,
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flit_vld,
    input  logic [CNT_W-1:0] thresh,
    input  logic [CNT_W-1:0] win_len,
    input  logic [OFF_W-1:0] off_len,
    output logic             link_en,
    output logic             win_done
);
    import lpg_pkg::*;

    lpg_phase_e       phase_q;
    logic             observing;
    logic             win_last;
    logic [CNT_W-1:0] util_total;
    logic             gate_now;
    logic             off_expire;

    // Observation runs only while the link is up.
    always_comb begin
        observing = (phase_q == PH_OBSERVE);
    end

    lpg_win_timer #(.CNT_W(CNT_W)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (observing),
        .win_len (win_len),
        .last    (win_last)
    );

    lpg_util_cnt #(.CNT_W(CNT_W)) u_util (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (win_last || !observing),
        .inc     (flit_vld && observing),
        .win_len (win_len),
        .total   (util_total)
    );

    // Gating decision at a window end against a non-zero threshold.
    always_comb begin
        gate_now = win_last && (thresh != '0) && (util_total < thresh);
    end

    lpg_off_timer #(.OFF_W(OFF_W)) u_off (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gate_now),
        .active  (!observing),
        .off_len (off_len),
        .expire  (off_expire)
    );

    // Phase register with registered link enable and window status pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_OBSERVE;
            link_en  <= 1'b1;
            win_done <= 1'b0;
        end else begin
            win_done <= win_last;
            case (phase_q)
                PH_OBSERVE: begin
                    if (gate_now) begin
                        phase_q <= PH_GATED;
                        link_en <= 1'b0;
                    end
                end
                PH_GATED: begin
                    if (off_expire) begin
                        phase_q <= PH_OBSERVE;
                        link_en <= 1'b1;
                    end
                end
                default: begin
                    phase_q <= PH_OBSERVE;
                    link_en <= 1'b1;
                end
            endcase
        end
    end

endmodule : lpg_ctrl

// File: rtl/lpg_ctrl_chk.sv
// Protocol checker for lpg_ctrl, bound to every instance of the top.
// Assumes: observes ports only.
module lpg_ctrl_chk #(
    parameter int CNT_W = 16,
    parameter int OFF_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flit_vld,
    input logic [CNT_W-1:0] thresh,
    input logic [CNT_W-1:0] win_len,
    input logic [OFF_W-1:0] off_len,
    input logic             link_en,
    input logic             win_done
);

    // R1: the cycle after reset is held, the link is up and no pulse is out.
    p_reset_up_r1: assert property (@(posedge clk)
        (!$past(rst_n) && rst_n) |-> (link_en && !win_done));

    // R3: the link only falls together with a window-end pulse.
    p_fall_at_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_en) |-> win_done);

    // R5: a zero threshold can never have caused a gating decision.
    p_zero_thresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_en) |-> ($past(thresh) != '0));

    // R7: no window is evaluated while the link is gated.
    p_no_eval_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_en && $past(!link_en)) |-> !win_done);

    // R8: every pulse follows a cycle in which the link was up.
    p_pulse_after_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> $past(link_en));

    // R6: waking starts a fresh window, so no pulse on the wake cycle.
    p_wake_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_en) |-> !win_done);

endmodule : lpg_ctrl_chk

bind lpg_ctrl lpg_ctrl_chk #(.CNT_W(CNT_W), .OFF_W(OFF_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flit_vld (flit_vld),
    .thresh   (thresh),
    .win_len  (win_len),
    .off_len  (off_len),
    .link_en  (link_en),
    .win_done (win_done)
);

// File: tb/tb_lpg_ctrl.sv
`timescale 1ns/1ps
// Self-checking bench for lpg_ctrl: vector table walk plus directed cases.
module tb_lpg_ctrl;

    localparam int CNT_W = 16;
    localparam int OFF_W = 16;
    localparam int NV    = 9;

    // Vector table: window, threshold, off time, valid cycles, gate expected.
    localparam int V_WIN [NV] = '{8, 8, 8, 16, 16, 4, 1, 6, 5};
    localparam int V_THR [NV] = '{4, 4, 0, 16, 16, 5, 1, 3, 2};
    localparam int V_OFF [NV] = '{3, 3, 3, 5, 5, 2, 1, 7, 1};
    localparam int V_NV  [NV] = '{2, 4, 0, 15, 16, 4, 0, 6, 1};
    localparam int V_GATE[NV] = '{1, 0, 0, 1, 0, 1, 1, 0, 1};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             flit_vld = 1'b0;
    logic [CNT_W-1:0] thresh = '0;
    logic [CNT_W-1:0] win_len = CNT_W'(4);
    logic [OFF_W-1:0] off_len = OFF_W'(1);
    logic             link_en;
    logic             win_done;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lpg_ctrl #(.CNT_W(CNT_W), .OFF_W(OFF_W)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .flit_vld (flit_vld),
        .thresh   (thresh),
        .win_len  (win_len),
        .off_len  (off_len),
        .link_en  (link_en),
        .win_done (win_done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reset for two cycles, program the fields, release at a falling edge.
    task automatic do_reset(input int w, input int t, input int o);
        @(negedge clk);
        rst_n = 1'b0; flit_vld = 1'b0;
        win_len = CNT_W'(w); thresh = CNT_W'(t); off_len = OFF_W'(o);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive one window starting at the current falling edge; return sampled
    // at the falling edge just after the decision edge.
    task automatic run_window(input int w, input int nvld);
        for (int i = 0; i < w; i++) begin
            flit_vld = (i < nvld);
            @(negedge clk);
        end
        flit_vld = 1'b0;
    endtask

    // Count gated cycles until link_en returns; drive flits meanwhile.
    task automatic measure_off(input bit busy, output int n);
        n = 0;
        while (!link_en && n < 1000) begin
            flit_vld = busy;
            @(negedge clk);
            n++;
        end
        flit_vld = 1'b0;
    endtask

    initial begin
        int n;
        // R1: reset state
        do_reset(4, 1, 1);
        check("R1 link_en after reset", int'(link_en), 1);
        check("R1 win_done after reset", int'(win_done), 0);

        // Table walk: R2 R3 R4 R5 R6 R8
        for (int v = 0; v < NV; v++) begin
            do_reset(V_WIN[v], V_THR[v], V_OFF[v]);
            run_window(V_WIN[v], V_NV[v]);
            check($sformatf("R3/R4 vec%0d link_en", v), int'(link_en), 1 - V_GATE[v]);
            check($sformatf("R8 vec%0d win_done", v), int'(win_done), 1);
            if (V_GATE[v] == 1) begin
                measure_off(1'b0, n);
                check($sformatf("R6 vec%0d off cycles", v), n, V_OFF[v]);
            end
        end

        // R5: zero threshold with an idle link over several windows
        do_reset(3, 0, 2);
        for (int k = 0; k < 4; k++) begin
            run_window(3, 0);
            check("R5 zero threshold keeps link up", int'(link_en), 1);
        end

        // R4: count clears between windows kept up
        do_reset(4, 3, 2);
        run_window(4, 4);
        check("R4 full window stays up", int'(link_en), 1);
        run_window(4, 2);
        check("R4 second window judged alone", int'(link_en), 0);

        // R7 and R6: flits during the gated interval are ignored, next window fresh
        do_reset(4, 1, 6);
        run_window(4, 0);
        check("R3 idle window gates", int'(link_en), 0);
        measure_off(1'b1, n);
        check("R7 off time with traffic", n, 6);
        check("R7 no pulse on wake", int'(win_done), 0);
        run_window(4, 0);
        check("R7 gated traffic not counted", int'(link_en), 0);
        measure_off(1'b0, n);

        // R6: off length zero behaves as one
        do_reset(2, 2, 0);
        run_window(2, 1);
        check("R3 one flit under threshold two", int'(link_en), 0);
        measure_off(1'b0, n);
        check("R6 zero off length", n, 1);

        // R2: window length zero behaves as one cycle
        do_reset(0, 1, 2);
        run_window(1, 1);
        check("R2 zero window with flit stays up", int'(link_en), 1);
        check("R8 zero window pulse", int'(win_done), 1);
        run_window(1, 0);
        check("R2 zero window idle gates", int'(link_en), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #1000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule : tb_lpg_ctrl